// File: doc/BRIEF.md
# Register-Mapped User Interrupt Generator

This block sits on an AXI4-Lite slave port and lets a host raise user interrupts toward a DMA or bridge core. Software sets a bit in a control word to ask for an interrupt on the matching line. The block then drives that line's request output until the core pulses the line's acknowledge. A status word shows, per line, whether the line is ready to take a new request.

Each request is gated by its line's ready bit. The control bit stays set until software clears it, so the host can read the control word during a level-style service routine and find which line fired. A line becomes ready again only after both the acknowledge has arrived and software has cleared the bit. The register space also holds a free scratch word and a read-only word that describes the size of the attached memory. That size code is fixed by parameters.

Top module: `uig_top`

## Requirements
- R1: The 32-bit words are decoded from address bits [ADDR_W-1:2], and address bits [1:0] are ignored. Word 0 (offset 0x00) is scratch. Word 1 (0x04) is the size descriptor. Word 2 (0x08) is interrupt control. Word 3 (0x0C) is interrupt status. After reset, control reads 0x00000000.
- R2: The size descriptor reads {24'b0, SIZE_EXP[3:0], SIZE_UNIT[3:0]}. The size is 2^SIZE_EXP units, and the unit codes are 0 = byte, 1 = KB, 2 = MB and 3 = GB. With the defaults the word reads 0x00000001, which means 1 KB.
- R3: Scratch is read/write, and each write strobe bit enables one byte lane: bit k covers data bits [8k+7:8k].
- R4: Writing 1 into a control bit that was 0, while the line's status bit is 1, raises irq_req for that line. The same write clears status bit i to 0. Both changes appear on the clock edge on which the write response becomes valid.
- R5: irq_req[i] stays high until irq_ack[i] is high for one cycle, and it falls on that edge. An acknowledge on a line that is not requesting has no effect.
- R6: A status bit returns to 1 only when the line has been acknowledged and its control bit has been cleared. The two events may come in either order. Status bit i is 1 when line i is ready and 0 while an interrupt is in progress.
- R7: A 0-to-1 write on a control bit while its status bit is 0 is ignored. No second interrupt is queued, and irq_req stays low after the line returns to ready.
- R8: Control is read/write, and it reads back its set bits while a request is pending. Control bits at N_LINES and above are not stored and read as 0.
- R9: Writes to the size and status words and to unmapped words receive bresp OKAY (2'b00) and change nothing. Reads of unmapped words return 0. Every rresp is OKAY.
- R10: The write address and write data channels may handshake in either order or in the same cycle. There is at most one outstanding transaction per direction. bvalid, rvalid and rdata hold until the matching ready is high.
- R11: A synchronous active-high reset clears scratch and control, sets every status bit to 1, drops every irq_req, and leaves bvalid and rvalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| irq_req | output | N_LINES | Per-line interrupt request |
| irq_ack | input | N_LINES | Per-line acknowledge pulse |

## Verification
The checks on request hold and response stability assume that the core raises irq_ack[i] for a single cycle. They also assume that a master keeps its ready signals free to stall the block's responses. The bench pulses one acknowledge at a time, for exactly one cycle. It also sends some acknowledges to lines that are not requesting. The return-to-ready property assumes reset is held for more than one cycle, so the bench holds it for several.

// File: rtl/uig_pkg.sv
package uig_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        REG_SCRATCH = 2'd0,
        REG_SIZE    = 2'd1,
        REG_CTRL    = 2'd2,
        REG_STATUS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    typedef struct packed {
        reg_dec_t            dec;
        logic [DATA_W-1:0]   data;
        logic [STRB_W-1:0]   strb;
    } wr_req_t;

    typedef enum logic [1:0] {
        LN_READY = 2'd0,
        LN_REQ   = 2'd1,
        LN_DRAIN = 2'd2
    } line_st_e;

    // word index -> register select; only the first four words are mapped
    function automatic reg_dec_t decode_word(logic [31:0] word);
        reg_dec_t d;
        d.hit = (word < 32'd4);
        d.sel = reg_sel_e'(word[1:0]);
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] size_code(int exp_v, int unit_v);
        return {24'd0, 4'(exp_v), 4'(unit_v)};
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(
        logic [DATA_W-1:0] old_v,
        logic [DATA_W-1:0] new_v,
        logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        res = old_v;
        for (int k = 0; k < STRB_W; k++) begin
            if (strb[k]) res[8*k +: 8] = new_v[8*k +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/uig_axil.sv
module uig_axil
    import uig_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              wr_en,
    output wr_req_t           wr_req,
    output reg_dec_t          rd_dec,
    input  logic [DATA_W-1:0] rd_word
);

    localparam logic [1:0] RESP_OKAY = 2'b00;

    logic              aw_held;
    logic              w_held;
    logic [ADDR_W-1:0] aw_addr_q;
    logic [DATA_W-1:0] w_data_q;
    logic [STRB_W-1:0] w_strb_q;
    logic              aw_hs;
    logic              w_hs;
    logic              ar_hs;
    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        unused_lsb;

    assign awready = !aw_held && !bvalid;
    assign wready  = !w_held && !bvalid;
    assign aw_hs   = awvalid && awready;
    assign w_hs    = wvalid && wready;
    assign wr_en   = (aw_held || aw_hs) && (w_held || w_hs);

    assign wr_addr     = aw_held ? aw_addr_q : awaddr;
    assign wr_req.dec  = decode_word(32'(wr_addr[ADDR_W-1:2]));
    assign wr_req.data = w_held ? w_data_q : wdata;
    assign wr_req.strb = w_held ? w_strb_q : wstrb;
    assign unused_lsb  = wr_addr[1:0] ^ araddr[1:0];

    assign bresp = RESP_OKAY;
    assign rresp = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held   <= 1'b0;
            w_held    <= 1'b0;
            bvalid    <= 1'b0;
            aw_addr_q <= '0;
            w_data_q  <= '0;
            w_strb_q  <= '0;
        end else if (wr_en) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b1;
        end else begin
            if (aw_hs) begin
                aw_held   <= 1'b1;
                aw_addr_q <= awaddr;
            end
            if (w_hs) begin
                w_held   <= 1'b1;
                w_data_q <= wdata;
                w_strb_q <= wstrb;
            end
            if (bvalid && bready) bvalid <= 1'b0;
        end
    end

    assign arready = !rvalid;
    assign ar_hs   = arvalid && arready;
    assign rd_dec  = decode_word(32'(araddr[ADDR_W-1:2]));

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (ar_hs) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/uig_regs.sv
module uig_regs
    import uig_pkg::*;
#(
    parameter int N_LINES   = 16,
    parameter int SIZE_EXP  = 0,
    parameter int SIZE_UNIT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  wr_req_t            wr_req,
    input  reg_dec_t           rd_dec,
    input  logic [N_LINES-1:0] line_rdy,
    output logic [DATA_W-1:0]  rd_word,
    output logic [N_LINES-1:0] ctrl_q,
    output logic [N_LINES-1:0] ctrl_rise
);

    localparam logic [DATA_W-1:0] SIZE_WORD = size_code(SIZE_EXP, SIZE_UNIT);

    logic [DATA_W-1:0]  scratch_q;
    logic [DATA_W-1:0]  ctrl_merged;
    logic [N_LINES-1:0] ctrl_next;
    logic               wr_scratch;
    logic               wr_ctrl;
    logic [DATA_W-1:0]  unused_ctrl_hi;

    assign wr_scratch = wr_en && wr_req.dec.hit && (wr_req.dec.sel == REG_SCRATCH);
    assign wr_ctrl    = wr_en && wr_req.dec.hit && (wr_req.dec.sel == REG_CTRL);

    assign ctrl_merged    = merge_bytes(DATA_W'(ctrl_q), wr_req.data, wr_req.strb);
    assign ctrl_next      = ctrl_merged[N_LINES-1:0];
    assign unused_ctrl_hi = ctrl_merged;
    assign ctrl_rise      = wr_ctrl ? (ctrl_next & ~ctrl_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            ctrl_q    <= '0;
        end else begin
            if (wr_scratch) scratch_q <= merge_bytes(scratch_q, wr_req.data, wr_req.strb);
            if (wr_ctrl)    ctrl_q    <= ctrl_next;
        end
    end

    always_comb begin
        rd_word = '0;
        if (rd_dec.hit) begin
            unique case (rd_dec.sel)
                REG_SCRATCH: rd_word = scratch_q;
                REG_SIZE:    rd_word = SIZE_WORD;
                REG_CTRL:    rd_word = DATA_W'(ctrl_q);
                REG_STATUS:  rd_word = DATA_W'(line_rdy);
                default:     rd_word = '0;
            endcase
        end
    end

endmodule

// File: rtl/uig_line.sv
module uig_line
    import uig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic ctrl,
    input  logic ack,
    output logic irq,
    output logic rdy
);

    line_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= LN_READY;
        end else begin
            unique case (st)
                LN_READY: if (rise) st <= LN_REQ;
                LN_REQ:   if (ack)  st <= ctrl ? LN_DRAIN : LN_READY;
                LN_DRAIN: if (!ctrl) st <= LN_READY;
                default:  st <= LN_READY;
            endcase
        end
    end

    assign irq = (st == LN_REQ);
    assign rdy = (st == LN_READY);

endmodule

// File: rtl/uig_top.sv
module uig_top
    import uig_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int N_LINES   = 16,
    parameter int SIZE_EXP  = 0,
    parameter int SIZE_UNIT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_wvalid,
    output logic               s_wready,
    input  logic [31:0]        s_wdata,
    input  logic [3:0]         s_wstrb,
    output logic               s_bvalid,
    input  logic               s_bready,
    output logic [1:0]         s_bresp,
    input  logic               s_arvalid,
    output logic               s_arready,
    input  logic [ADDR_W-1:0]  s_araddr,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic [N_LINES-1:0] irq_req,
    input  logic [N_LINES-1:0] irq_ack
);

    logic               wr_en;
    wr_req_t            wr_req;
    reg_dec_t           rd_dec;
    logic [DATA_W-1:0]  rd_word;
    logic [N_LINES-1:0] ctrl_q;
    logic [N_LINES-1:0] ctrl_rise;
    logic [N_LINES-1:0] line_rdy;

    uig_axil #(.ADDR_W(ADDR_W)) u_axil (
        .clk     (clk),
        .rst     (rst),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .awaddr  (s_awaddr),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .bresp   (s_bresp),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .araddr  (s_araddr),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .wr_en   (wr_en),
        .wr_req  (wr_req),
        .rd_dec  (rd_dec),
        .rd_word (rd_word)
    );

    uig_regs #(
        .N_LINES   (N_LINES),
        .SIZE_EXP  (SIZE_EXP),
        .SIZE_UNIT (SIZE_UNIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_req    (wr_req),
        .rd_dec    (rd_dec),
        .line_rdy  (line_rdy),
        .rd_word   (rd_word),
        .ctrl_q    (ctrl_q),
        .ctrl_rise (ctrl_rise)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        uig_line u_line (
            .clk  (clk),
            .rst  (rst),
            .rise (ctrl_rise[i]),
            .ctrl (ctrl_q[i]),
            .ack  (irq_ack[i]),
            .irq  (irq_req[i]),
            .rdy  (line_rdy[i])
        );
    end

endmodule

// File: rtl/uig_chk.sv
module uig_chk #(
    parameter int N_LINES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               bvalid,
    input logic               bready,
    input logic               rvalid,
    input logic               rready,
    input logic [31:0]        rdata,
    input logic [N_LINES-1:0] irq,
    input logic [N_LINES-1:0] ack,
    input logic [N_LINES-1:0] rdy,
    input logic [N_LINES-1:0] ctrl
);

    // R10
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        // R5
        irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (irq[i] && !ack[i]) |=> irq[i]);

        // R4
        irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(rdy[i]));

        // R6
        ready_return_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(rdy[i]) |-> $past(!ctrl[i]));
    end

endmodule

bind uig_top uig_chk #(.N_LINES(N_LINES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .bvalid (s_bvalid),
    .bready (s_bready),
    .rvalid (s_rvalid),
    .rready (s_rready),
    .rdata  (s_rdata),
    .irq    (irq_req),
    .ack    (irq_ack),
    .rdy    (line_rdy),
    .ctrl   (ctrl_q)
);

// File: tb/uig_top_tb.sv
module uig_top_tb;

    localparam int ADDR_W = 12;
    localparam int NL     = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
    logic              arvalid = 1'b0, rready = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic [31:0]       wdata = '0;
    logic [3:0]        wstrb = '0;
    logic              awready, wready, bvalid, arready, rvalid;
    logic [1:0]        bresp, rresp;
    logic [31:0]       rdata;
    logic [NL-1:0]     irq_req;
    logic [NL-1:0]     irq_ack = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uig_top #(.ADDR_W(ADDR_W), .N_LINES(NL)) u_dut (
        .clk(clk), .rst(rst),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
        .irq_req(irq_req), .irq_ack(irq_ack)
    );

    localparam logic [11:0] A_SCR = 12'h000, A_SIZE = 12'h004,
                            A_CTRL = 12'h008, A_STAT = 12'h00C;

    typedef struct packed {
        logic        wr;
        logic [1:0]  mode;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 4'd3,  12'h000, 32'hDEADBEEF, 4'hF, 32'h0},          // R3
        '{1'b0, 2'd0, 4'd3,  12'h000, 32'h0, 4'h0, 32'hDEADBEEF},
        '{1'b1, 2'd1, 4'd10, 12'h000, 32'h11223344, 4'h1, 32'h0},          // R10 aw first
        '{1'b0, 2'd0, 4'd3,  12'h000, 32'h0, 4'h0, 32'hDEADBE44},
        '{1'b1, 2'd2, 4'd10, 12'h000, 32'h55667788, 4'h6, 32'h0},          // R10 w first
        '{1'b0, 2'd0, 4'd3,  12'h000, 32'h0, 4'h0, 32'hDE667744},
        '{1'b0, 2'd0, 4'd2,  12'h004, 32'h0, 4'h0, 32'h00000001},          // R2
        '{1'b1, 2'd0, 4'd9,  12'h004, 32'h12345678, 4'hF, 32'h0},          // R9
        '{1'b0, 2'd0, 4'd9,  12'h004, 32'h0, 4'h0, 32'h00000001},
        '{1'b1, 2'd1, 4'd9,  12'h00C, 32'h0, 4'hF, 32'h0},
        '{1'b0, 2'd0, 4'd9,  12'h00C, 32'h0, 4'h0, 32'h0000FFFF},
        '{1'b1, 2'd2, 4'd9,  12'h010, 32'hCAFEF00D, 4'hF, 32'h0},
        '{1'b0, 2'd0, 4'd9,  12'h010, 32'h0, 4'h0, 32'h0},
        '{1'b0, 2'd0, 4'd9,  12'hFFC, 32'h0, 4'h0, 32'h0},
        '{1'b0, 2'd0, 4'd9,  12'h002, 32'h0, 4'h0, 32'hDE667744},          // R1 low bits ignored
        '{1'b0, 2'd0, 4'd1,  12'h008, 32'h0, 4'h0, 32'h0}                  // R1
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // mode 0: both channels together, 1: address first, 2: data first
    task automatic axi_wr(logic [11:0] a, logic [31:0] d, logic [3:0] s, int mode,
                          output logic [1:0] resp);
        bit aw_done = 0, w_done = 0, ah, wh;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; bready = 1'b1;
        if (mode != 2) awvalid = 1'b1;
        if (mode != 1) wvalid = 1'b1;
        while (!(aw_done && w_done)) begin
            ah = awvalid && awready;
            wh = wvalid && wready;
            @(negedge clk);
            if (ah) begin awvalid = 1'b0; aw_done = 1; end
            if (wh) begin wvalid = 1'b0; w_done = 1; end
            if (mode == 1 && aw_done && !w_done) wvalid = 1'b1;
            if (mode == 2 && w_done && !aw_done) awvalid = 1'b1;
        end
        while (!bvalid) @(negedge clk);
        resp = bresp;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic axi_rd(logic [11:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        araddr = a; arvalid = 1'b1; rready = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        d = rdata; resp = rresp;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic wr_chk(string tag, logic [11:0] a, logic [31:0] d);
        logic [1:0] r;
        axi_wr(a, d, 4'hF, 0, r);
        chk({tag, " bresp"}, 32'(r), 32'h0);
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v; logic [1:0] r;
        axi_rd(a, v, r);
        chk(tag, v, exp);
    endtask

    task automatic pulse_ack(int ln);
        @(negedge clk);
        irq_ack = NL'(1) << ln;
        @(negedge clk);
        irq_ack = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v; logic [1:0] r;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 irq after reset", 32'(irq_req), 32'h0);
        chk("R11 bvalid/rvalid after reset", {30'd0, bvalid, rvalid}, 32'h0);
        rd_chk("R11 status after reset", A_STAT, 32'h0000FFFF);
        rd_chk("R11 ctrl after reset", A_CTRL, 32'h0);
        rd_chk("R11 scratch after reset", A_SCR, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                axi_wr(VECS[i].addr, VECS[i].data, VECS[i].strb, int'(VECS[i].mode), r);
                chk($sformatf("R%0d vec%0d bresp", VECS[i].req, i), 32'(r), VECS[i].exp);
            end else begin
                axi_rd(VECS[i].addr, v, r);
                chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), v, VECS[i].exp);
                chk($sformatf("R9 vec%0d rresp", i), 32'(r), 32'h0);
            end
        end

        // line 0: request, hold, ack, then clear
        wr_chk("R4", A_CTRL, 32'h1);
        chk("R4 irq raised", 32'(irq_req), 32'h0001);
        rd_chk("R4 status busy", A_STAT, 32'h0000FFFE);
        rd_chk("R8 ctrl shows source", A_CTRL, 32'h1);
        wr_chk("R7", A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        chk("R5 irq held without ack", 32'(irq_req), 32'h0001);
        pulse_ack(2);
        chk("R5 foreign ack ignored", 32'(irq_req), 32'h0001);
        pulse_ack(0);
        chk("R5 irq dropped on ack", 32'(irq_req), 32'h0);
        rd_chk("R6 status waits for clear", A_STAT, 32'h0000FFFE);
        wr_chk("R6", A_CTRL, 32'h0);
        rd_chk("R6 status ready after clear", A_STAT, 32'h0000FFFF);

        // line 3: re-request while busy is not queued
        wr_chk("R4", A_CTRL, 32'h8);
        wr_chk("R6", A_CTRL, 32'h0);
        rd_chk("R6 cleared before ack still busy", A_STAT, 32'h0000FFF7);
        wr_chk("R7", A_CTRL, 32'h8);
        chk("R7 irq unchanged by busy write", 32'(irq_req), 32'h0008);
        pulse_ack(3);
        chk("R5 irq3 dropped", 32'(irq_req), 32'h0);
        rd_chk("R6 ctrl set keeps busy", A_STAT, 32'h0000FFF7);
        wr_chk("R6", A_CTRL, 32'h0);
        repeat (4) @(negedge clk);
        chk("R7 no queued interrupt", 32'(irq_req), 32'h0);
        rd_chk("R6 line3 ready", A_STAT, 32'h0000FFFF);

        // line 5: clear before ack
        wr_chk("R4", A_CTRL, 32'h20);
        wr_chk("R6", A_CTRL, 32'h0);
        pulse_ack(5);
        rd_chk("R6 ack after clear gives ready", A_STAT, 32'h0000FFFF);

        // several lines at once
        wr_chk("R4", A_CTRL, 32'h6);
        chk("R4 two lines raised", 32'(irq_req), 32'h0006);
        pulse_ack(1);
        chk("R5 only line1 dropped", 32'(irq_req), 32'h0004);
        pulse_ack(2);
        wr_chk("R6", A_CTRL, 32'h0);
        rd_chk("R6 all ready", A_STAT, 32'h0000FFFF);

        // ack on idle line
        pulse_ack(7);
        chk("R5 idle ack no irq", 32'(irq_req), 32'h0);
        rd_chk("R5 idle ack status", A_STAT, 32'h0000FFFF);

        // bits above the line count
        wr_chk("R8", A_CTRL, 32'hFFFF0000);
        rd_chk("R8 upper ctrl bits read zero", A_CTRL, 32'h0);
        chk("R8 no irq from upper bits", 32'(irq_req), 32'h0);

        // reset during a pending request
        wr_chk("R11", A_SCR, 32'hA5A5A5A5);
        wr_chk("R4", A_CTRL, 32'h80);
        chk("R4 line7 raised", 32'(irq_req), 32'h0080);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R11 irq cleared by reset", 32'(irq_req), 32'h0);
        rd_chk("R11 status ready after reset", A_STAT, 32'h0000FFFF);
        rd_chk("R11 ctrl cleared", A_CTRL, 32'h0);
        rd_chk("R11 scratch cleared", A_SCR, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule